// File: doc/BRIEF.md
# Bulk Erase Sequencer

This block is a host-side controller that runs the closed-loop bulk erase procedure on a flash memory with a command interface. After one `start` pulse it raises the high-voltage enable and applies an erase pulse. An erase pulse is two consecutive writes of the erase opcode, followed by a timed wait. It then walks the array byte by byte. For each byte it writes the verify opcode with that byte's address, waits a short recovery time and reads the byte back. The caller must already have programmed every byte to 00h.

A byte that reads back FFh is erased, and the walk moves to the next address without another erase. Any other value makes the whole chip erase again, and verification resumes at the byte that failed. One pulse budget covers the whole job. If that budget runs out, the job stops with an error. When the top address passes, the block writes the read-mode opcode, removes the high-voltage enable and reports completion. The done and error results are each pulsed for one clock and held in a flag until the next start. All bus traffic uses a request/acknowledge port. Both wait times are counted in clock cycles and are set by parameters.

Top module: `erase_sequencer`

## Requirements
- R1: A `start` pulse while idle sets the verify address to 0 and raises `hvEn` in the following cycle. The first transaction is a write of 20h. `hvEn` stays high during every bus request of the job.
- R2: An erase pulse is two back-to-back writes of 20h. After the second one is acknowledged, at least ERASE_WAIT clock cycles pass before the next request, which is a write of A0h.
- R3: Each write of A0h carries the address of the byte to verify on `busAddr`. After it is acknowledged, at least VERIFY_WAIT clock cycles pass before a read (`busWr` = 0) of that same address.
- R4: A read returning FFh counts as a pass. The next transaction is a write of A0h at the address plus one, with no erase pulse in between.
- R5: A read returning any value other than FFh starts another erase pulse. The next write of A0h after that pulse carries the failing address, not address 0.
- R6: The job applies at most MAX_PULSES erase pulses. A failed read after the last allowed pulse ends the job: `errPulse` is high for one cycle, `errFlag` is set, `hvEn` drops to 0, the read-mode write is skipped and no further requests follow.
- R7: When the top address (all ones) passes, the block writes FFh. After that write is acknowledged, `hvEn` drops to 0, `donePulse` is high for exactly one cycle and `doneFlag` is set. `donePulse` and `errPulse` are never high together.
- R8: `doneFlag` and `errFlag` keep their value after the job ends, until the next accepted `start` clears them. A `start` during a running job is ignored.
- R9: After reset, `busReq`, `hvEn`, `donePulse`, `errPulse`, `doneFlag` and `errFlag` are all 0.
- R10: Once `busReq` is raised, it stays high and `busAddr`, `busWr` and `busWdata` stay unchanged until the cycle in which `busAck` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a job when idle |
| busReq | output | 1 | Bus transaction request |
| busWr | output | 1 | 1 = write, 0 = read |
| busAddr | output | ADDR_W | Transaction address |
| busWdata | output | 8 | Write data (command opcode) |
| busRdata | input | 8 | Read data, valid while busAck is high |
| busAck | input | 1 | Completes the pending request |
| hvEn | output | 1 | High-voltage enable for the flash |
| donePulse | output | 1 | One-cycle pulse on successful completion |
| errPulse | output | 1 | One-cycle pulse when the pulse budget runs out |
| doneFlag | output | 1 | Held success result |
| errFlag | output | 1 | Held error result |

## Verification
The bench builds the block with ADDR_W = 3, ERASE_WAIT = 12, VERIFY_WAIT = 4 and MAX_PULSES = 4. With these values a full walk of the eight-byte array takes only a few hundred cycles. Failures at the first byte, in the middle and at the top address can all be forced. The pulse budget can be used up exactly, or run out, within a single short job. The bench's flash model decides how many erase pulses each byte needs before it reads FFh. The model also acknowledges each request one cycle late, so that the hold rule on a pending request is actually exercised.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] OP_ERASE    = 8'h20;
  localparam logic [7:0] OP_VERIFY   = 8'hA0;
  localparam logic [7:0] OP_READMODE = 8'hFF;
  localparam logic [7:0] BYTE_CLEAN  = 8'hFF;

  typedef enum logic [1:0] {
    BK_ERASE,
    BK_VERIFY,
    BK_READ,
    BK_RESET
  } busKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERS1,
    ST_ERS2,
    ST_EWAIT,
    ST_VCMD,
    ST_VWAIT,
    ST_VREAD,
    ST_RST
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic     clrJob;
    logic     incAddr;
    logic     incPulse;
    logic     loadLong;
    logic     loadShort;
    logic     issue;
    busKind_e kind;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ack;
    logic pass;
    logic lastAddr;
    logic atLimit;
    logic timerZero;
  } dpStatus_t;

endpackage

// File: rtl/erase_seq_dpath.sv
module erase_seq_dpath
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300,
  parameter int MAX_PULSES  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output dpStatus_t         status,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata,
  input  logic              busAck
);

  localparam int LONGEST = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int PCNT_W  = $clog2(MAX_PULSES + 1);
  localparam logic [TMR_W-1:0]  LONG_LOAD  = TMR_W'(ERASE_WAIT - 1);
  localparam logic [TMR_W-1:0]  SHORT_LOAD = TMR_W'(VERIFY_WAIT - 1);
  localparam logic [PCNT_W-1:0] LAST_PULSE = PCNT_W'(MAX_PULSES - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR   = {ADDR_W{1'b1}};

  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] addrNext;
  logic [PCNT_W-1:0] pulseCnt;
  logic [TMR_W-1:0]  timer;
  logic [7:0]        opcode;
  logic              addrCarried;

  // the verify issued together with an address step must see the new address
  assign addrNext = strobe.incAddr ? curAddr + 1'b1 : curAddr;

  always_comb begin
    opcode      = 8'h00;
    addrCarried = 1'b0;
    unique case (strobe.kind)
      BK_ERASE:  opcode = OP_ERASE;
      BK_VERIFY: begin opcode = OP_VERIFY; addrCarried = 1'b1; end
      BK_READ:   addrCarried = 1'b1;
      BK_RESET:  opcode = OP_READMODE;
      default:   opcode = 8'h00;
    endcase
  end

  // job counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      pulseCnt <= '0;
    end else if (strobe.clrJob) begin
      curAddr  <= '0;
      pulseCnt <= '0;
    end else begin
      if (strobe.incAddr)  curAddr  <= curAddr + 1'b1;
      if (strobe.incPulse) pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // one down-counter serves both waits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.loadLong)  timer <= LONG_LOAD;
    else if (strobe.loadShort) timer <= SHORT_LOAD;
    else if (timer != '0)      timer <= timer - 1'b1;
  end

  // bus request register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReq   <= 1'b0;
      busWr    <= 1'b0;
      busAddr  <= '0;
      busWdata <= '0;
    end else if (strobe.issue) begin
      busReq   <= 1'b1;
      busWr    <= (strobe.kind != BK_READ);
      busAddr  <= addrCarried ? addrNext : '0;
      busWdata <= opcode;
    end else if (busReq && busAck) begin
      busReq   <= 1'b0;
    end
  end

  assign status.ack       = busReq && busAck;
  assign status.pass      = (busRdata == BYTE_CLEAN);
  assign status.lastAddr  = (curAddr == TOP_ADDR);
  assign status.atLimit   = (pulseCnt == LAST_PULSE);
  assign status.timerZero = (timer == '0);

  // R10: a pending request holds its contents until acknowledged
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(busAddr) && $stable(busWr) && $stable(busWdata)));

  // R10: control never issues over an unfinished request
  p_no_overissue_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (!busReq || busAck));

  // R6: the pulse count never passes the budget
  p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCnt <= LAST_PULSE));

endmodule

// File: rtl/erase_seq_ctrl.sv
module erase_seq_ctrl
  import erase_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        hvEn,
  output logic        donePulse,
  output logic        errPulse,
  output logic        doneFlag,
  output logic        errFlag
);

  seqState_e state, stateNext;
  logic launch, finishOk, finishErr;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    launch    = 1'b0;
    finishOk  = 1'b0;
    finishErr = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        launch        = 1'b1;
        strobe.clrJob = 1'b1;
        strobe.issue  = 1'b1;
        strobe.kind   = BK_ERASE;
        stateNext     = ST_ERS1;
      end
      ST_ERS1: if (status.ack) begin
        strobe.issue = 1'b1;
        strobe.kind  = BK_ERASE;
        stateNext    = ST_ERS2;
      end
      ST_ERS2: if (status.ack) begin
        strobe.loadLong = 1'b1;
        stateNext       = ST_EWAIT;
      end
      ST_EWAIT: if (status.timerZero) begin
        strobe.issue = 1'b1;
        strobe.kind  = BK_VERIFY;
        stateNext    = ST_VCMD;
      end
      ST_VCMD: if (status.ack) begin
        strobe.loadShort = 1'b1;
        stateNext        = ST_VWAIT;
      end
      ST_VWAIT: if (status.timerZero) begin
        strobe.issue = 1'b1;
        strobe.kind  = BK_READ;
        stateNext    = ST_VREAD;
      end
      ST_VREAD: if (status.ack) begin
        if (status.pass) begin
          strobe.issue = 1'b1;
          if (status.lastAddr) begin
            strobe.kind = BK_RESET;
            stateNext   = ST_RST;
          end else begin
            strobe.incAddr = 1'b1;
            strobe.kind    = BK_VERIFY;
            stateNext      = ST_VCMD;
          end
        end else if (status.atLimit) begin
          finishErr = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          strobe.incPulse = 1'b1;
          strobe.issue    = 1'b1;
          strobe.kind     = BK_ERASE;
          stateNext       = ST_ERS1;
        end
      end
      ST_RST: if (status.ack) begin
        finishOk  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hvEn      <= 1'b0;
      donePulse <= 1'b0;
      errPulse  <= 1'b0;
      doneFlag  <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      state     <= stateNext;
      donePulse <= finishOk;
      errPulse  <= finishErr;
      if (launch) begin
        hvEn     <= 1'b1;
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end
      if (finishOk) begin
        hvEn     <= 1'b0;
        doneFlag <= 1'b1;
      end
      if (finishErr) begin
        hvEn    <= 1'b0;
        errFlag <= 1'b1;
      end
    end
  end

  // R7: the two results are exclusive and the done pulse lasts one cycle
  p_one_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(donePulse && errPulse));
  p_done_once_r7: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R6: an error leaves the high voltage off
  p_err_hv_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> (!hvEn && errFlag));

  // R8: an accepted start clears both flags and raises the high voltage
  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> (!doneFlag && !errFlag && hvEn));

endmodule

// File: rtl/erase_sequencer.sv
module erase_sequencer
  import erase_seq_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int ERASE_WAIT  = 500000,
  parameter int VERIFY_WAIT = 300,
  parameter int MAX_PULSES  = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busReq,
  output logic              busWr,
  output logic [ADDR_W-1:0] busAddr,
  output logic [7:0]        busWdata,
  input  logic [7:0]        busRdata,
  input  logic              busAck,
  output logic              hvEn,
  output logic              donePulse,
  output logic              errPulse,
  output logic              doneFlag,
  output logic              errFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  erase_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .status    (status),
    .strobe    (strobe),
    .hvEn      (hvEn),
    .donePulse (donePulse),
    .errPulse  (errPulse),
    .doneFlag  (doneFlag),
    .errFlag   (errFlag)
  );

  erase_seq_dpath #(
    .ADDR_W      (ADDR_W),
    .ERASE_WAIT  (ERASE_WAIT),
    .VERIFY_WAIT (VERIFY_WAIT),
    .MAX_PULSES  (MAX_PULSES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .status   (status),
    .busReq   (busReq),
    .busWr    (busWr),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .busAck   (busAck)
  );

  // R1: no bus request goes out without the high voltage applied
  p_hv_covers_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> hvEn);

endmodule

// File: tb/tb_erase_sequencer.sv
module tb_erase_sequencer;

  localparam int ADDR_W = 3;
  localparam int EW     = 12;
  localparam int VW     = 4;
  localparam int MAXP   = 4;
  localparam int NVEC   = 5;

  // per-vector: erase pulses each byte needs (nibble per address, address 0 lowest)
  localparam logic [31:0] V_NEED [NVEC] = '{32'h11111111, 32'h00300000, 32'h30000002,
                                            32'h00005000, 32'h40000000};
  localparam bit V_ERR   [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int V_ERASE [NVEC] = '{1, 3, 3, 4, 4};
  localparam int V_READS [NVEC] = '{8, 10, 10, 7, 11};

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic busReq, busWr, busAck = 1'b0;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWdata, busRdata = 8'h00;
  logic hvEn, donePulse, errPulse, doneFlag, errFlag;

  int nChecks = 0, nFail = 0, cyc = 0;
  int erases, reads, verifies, ffWrites, badCmd, hvBad, holdBad, addrBad, seqBad, resumeBad;
  int txAfter, pulsesApplied, minEGap, minVGap, lastEraseCyc, lastVerCyc;
  bit halfErase, afterErase, pendActive, runEnded;
  logic [31:0] curNeed;
  logic [ADDR_W-1:0] lastVerAddr, lastFailAddr, capAddr;
  logic capWr;
  logic [7:0] capData;

  always #10 clk = ~clk;

  erase_sequencer #(.ADDR_W(ADDR_W), .ERASE_WAIT(EW), .VERIFY_WAIT(VW), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .busReq(busReq), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .hvEn(hvEn),
    .donePulse(donePulse), .errPulse(errPulse), .doneFlag(doneFlag), .errFlag(errFlag));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int needOf(input logic [31:0] v, input logic [ADDR_W-1:0] a);
    int idx = int'(a);
    return int'(v[idx*4 +: 4]);
  endfunction

  task automatic clearLog();
    erases = 0; reads = 0; verifies = 0; ffWrites = 0; badCmd = 0; hvBad = 0; holdBad = 0;
    addrBad = 0; seqBad = 0; resumeBad = 0; txAfter = 0; pulsesApplied = 0;
    minEGap = 1000000; minVGap = 1000000; lastEraseCyc = 0; lastVerCyc = 0;
    halfErase = 0; afterErase = 0; runEnded = 0; lastVerAddr = '0; lastFailAddr = '0;
  endtask

  // flash model: acknowledges each request one cycle late, logs the traffic
  always @(negedge clk) begin
    cyc++;
    if (busAck) busAck = 1'b0;
    else if (busReq) begin
      if (!pendActive) begin
        pendActive = 1; capAddr = busAddr; capWr = busWr; capData = busWdata;
      end else begin
        if (busAddr != capAddr || busWr != capWr || busWdata != capData) holdBad++;
        pendActive = 0;
        busAck = 1'b1;
        if (runEnded) txAfter++;
        if (!hvEn) hvBad++;
        if (capWr) begin
          if (capData == 8'h20) begin
            if (halfErase) begin
              erases++; pulsesApplied++; halfErase = 0; afterErase = 1; lastEraseCyc = cyc;
            end else halfErase = 1;
          end else begin
            halfErase = 0;
            if (capData == 8'hA0) begin
              verifies++;
              if (afterErase) begin
                if (cyc - lastEraseCyc < minEGap) minEGap = cyc - lastEraseCyc;
                if (capAddr != lastFailAddr) resumeBad++;
                afterErase = 0;
              end else if (capAddr != ADDR_W'(lastVerAddr + 1'b1)) seqBad++;
              lastVerAddr = capAddr; lastVerCyc = cyc;
            end else if (capData == 8'hFF) ffWrites++;
            else badCmd++;
          end
        end else begin
          reads++;
          if (cyc - lastVerCyc < minVGap) minVGap = cyc - lastVerCyc;
          if (capAddr != lastVerAddr) addrBad++;
          if (pulsesApplied >= needOf(curNeed, capAddr)) busRdata = 8'hFF;
          else begin busRdata = 8'h5A; lastFailAddr = capAddr; end
        end
      end
    end else if (pendActive) begin
      holdBad++; pendActive = 0;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(negedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    curNeed = V_NEED[0];
    pendActive = 0;
    clearLog();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(!busReq && !hvEn, "R9 bus/hv idle after reset", int'({busReq, hvEn}), 0);
    check(!donePulse && !errPulse && !doneFlag && !errFlag, "R9 results clear after reset",
          int'({donePulse, errPulse, doneFlag, errFlag}), 0);

    for (int v = 0; v < NVEC; v++) begin
      int waitCnt = 0;
      bit sawErr = 0, sawDone = 0;
      clearLog();
      curNeed = V_NEED[v];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R1 high voltage raised; R8 flags cleared by the accepted start
      check(hvEn == 1'b1, "R1 hvEn after start", int'(hvEn), 1);
      check(!doneFlag && !errFlag, "R8 start clears flags", int'({doneFlag, errFlag}), 0);
      while (!donePulse && !errPulse && waitCnt < 5000) begin
        if (v == 1 && waitCnt == 25) start = 1'b1;   // R8: ignored while busy
        else start = 1'b0;
        @(negedge clk);
        waitCnt++;
      end
      start = 1'b0;
      sawDone = donePulse; sawErr = errPulse;
      runEnded = 1;
      check(waitCnt < 5000, "R7 job finishes", waitCnt, 0);
      check(sawErr == V_ERR[v] && sawDone == !V_ERR[v], "R6/R7 result kind",
            int'({sawDone, sawErr}), V_ERR[v] ? 1 : 2);
      check(!hvEn, "R6 R7 hvEn off at end", int'(hvEn), 0);
      check(erases == V_ERASE[v], "R2 R5 R6 erase pulse count", erases, V_ERASE[v]);
      check(reads == V_READS[v], "R4 R5 verify read count", reads, V_READS[v]);
      check(verifies == reads, "R3 one verify write per read", verifies, reads);
      check(ffWrites == (V_ERR[v] ? 0 : 1), "R7 read-mode write", ffWrites, V_ERR[v] ? 0 : 1);
      check(minEGap >= EW, "R2 erase wait", minEGap, EW);
      check(minVGap >= VW, "R3 recovery wait", minVGap, VW);
      check(addrBad == 0, "R3 read address matches verify", addrBad, 0);
      check(seqBad == 0, "R4 pass steps address", seqBad, 0);
      check(resumeBad == 0, "R1 R5 verify resumes at failing address", resumeBad, 0);
      check(hvBad == 0 && badCmd == 0, "R1 hv held during requests", hvBad + badCmd, 0);
      check(holdBad == 0, "R10 pending request held", holdBad, 0);
      repeat (3) @(negedge clk);
      check(!donePulse && !errPulse, "R7 result pulse one cycle", int'({donePulse, errPulse}), 0);
      check(doneFlag == !V_ERR[v] && errFlag == V_ERR[v], "R8 flags held",
            int'({doneFlag, errFlag}), V_ERR[v] ? 1 : 2);
      check(txAfter == 0 && !busReq, "R6 no traffic after end", txAfter, 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule